// File: doc/BRIEF.md
# Branch Trace Recording Unit

The unit observes a stream of retirement events from a processor core. Each event carries a two-bit kind (not-taken branch, taken branch, interrupt or exception), a source address and a destination address. Every event except a not-taken branch is a qualifying event, and a single control word decides what the unit does with it. It can push the address pair onto a small circular history stack. It can emit a trace message. It can also write a record into a memory buffer whose base, limit and fill index are held in their own registers.

Software reaches every register through a simple write strobe and a combinational read port. When the buffer fills, the unit either raises a level interrupt and stops logging, or wraps back to the buffer base and overwrites old records. The control word selects which of the two happens.

Top module: `brt_unit`

## Requirements
- R1: The control word answers at register address 0x1D9 and keeps only bits 0, 1, 6, 7 and 8; all other bits read as 0 whatever is written, and reset clears the word to 0.
- R2: With control bit 0 set, every qualifying event (kind 1 taken branch, 2 interrupt, 3 exception) advances the top-of-stack pointer (address 0x1DD) by one on the following clock edge and stores the pair at the new top; entry i reads back its source at 0x040+2i and its destination at 0x041+2i. With bit 0 clear the stack is unchanged.
- R3: The stack holds 8 entries; the pointer wraps from 7 to 0, so the ninth record overwrites the oldest one.
- R4: A not-taken branch (kind 0) produces no stack push, no message and no buffer write.
- R5: Control bit 1 is stored and read back but changes neither stack, message nor buffer behaviour.
- R6: With control bit 6 set, a qualifying event produces msg_valid high for exactly one cycle after the capturing edge, with msg_data = {kind, source, destination}; with bit 6 clear no message appears.
- R7: A buffer write takes place only when both bit 6 and bit 7 are set. The write is presented one cycle after the event at address base + 8*index, with data {source, destination}, and the index then advances. Base is at 0x1DA, limit at 0x1DB and index at 0x1DC.
- R8: With control bit 8 set, the write that brings the index to the limit also raises buf_irq. From then on logging is suppressed, and buf_irq stays high until software writes the index register, which clears it.
- R9: With control bit 8 clear, the index returns to 0 after the slot just below the limit, so the next record is written at the base and overwrites.
- R10: A write to the index register in the same cycle as a loggable event takes priority, and that event writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Retirement event present this cycle |
| evt_kind | input | 2 | 0 not-taken branch, 1 taken branch, 2 interrupt, 3 exception |
| evt_from | input | ADDR_W | Source address of the event |
| evt_to | input | ADDR_W | Destination address of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msg_valid | output | 1 | Trace message present |
| msg_data | output | 2*ADDR_W+2 | {kind, source, destination} |
| buf_we | output | 1 | Buffer record write strobe |
| buf_addr | output | ADDR_W | Byte address of the record |
| buf_wdata | output | 2*ADDR_W | {source, destination} |
| buf_irq | output | 1 | Level interrupt, buffer full |

## Verification
Register reads are combinational, so the bench reads a value in the same low clock phase in which it sets the address. Stack, message and buffer results are all registered once. They are due after the first rising edge that sees the event or the register write. The bench drives every input on a falling edge and checks msg_valid, buf_we, buf_addr and buf_irq at the next falling edge, one edge after the stimulus. It does the same for the stack pointer and the index read back through the register port. The memory model in the bench commits a write on the edge after it is presented, so buffer contents are checked one further cycle later.

// File: rtl/brt_pkg.sv
// Package: shared constants for the branch trace recording unit.
// Assumes a 12-bit register address space and 32-bit register data.
package brt_pkg;
    localparam int REG_W  = 32;
    localparam int RA_W   = 12;

    // Event kinds carried on evt_kind
    localparam logic [1:0] EV_NOTTAKEN = 2'd0;
    localparam logic [1:0] EV_TAKEN    = 2'd1;
    localparam logic [1:0] EV_INTR     = 2'd2;
    localparam logic [1:0] EV_EXCP     = 2'd3;

    // Register addresses
    localparam logic [RA_W-1:0] A_CTRL  = 12'h1D9;
    localparam logic [RA_W-1:0] A_BASE  = 12'h1DA;
    localparam logic [RA_W-1:0] A_LIMIT = 12'h1DB;
    localparam logic [RA_W-1:0] A_INDEX = 12'h1DC;
    localparam logic [RA_W-1:0] A_TOS   = 12'h1DD;
    localparam logic [RA_W-1:0] A_HIST  = 12'h040;

    // Control bit positions
    localparam int CB_HIST = 0;
    localparam int CB_STEP = 1;
    localparam int CB_MSG  = 6;
    localparam int CB_LOG  = 7;
    localparam int CB_FULL = 8;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << CB_HIST) | (REG_W'(1) << CB_STEP) | (REG_W'(1) << CB_MSG) |
        (REG_W'(1) << CB_LOG)  | (REG_W'(1) << CB_FULL);
endpackage

// File: rtl/brt_ctrl_reg.sv
// Module: control word storage.
// Holds only the implemented bits; unimplemented bits are dropped on write.
// Assumes wr_en is already address-decoded by the parent.
module brt_ctrl_reg
    import brt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_word
);
    // Store the masked control word
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_word <= '0;
        else if (wr_en) ctrl_word <= wdata & CTRL_MASK;
    end

    // R1
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl_word & ~CTRL_MASK) == '0) &&
                  ((ctrl_word & CTRL_MASK) == ($past(wdata) & CTRL_MASK)));
    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_word));
endmodule

// File: rtl/brt_hist_stack.sv
// Module: circular history stack of source/destination pairs.
// The pointer pre-increments on a push, so it always names the newest entry.
// Assumes DEPTH is a power of two, so the pointer wraps naturally.
module brt_hist_stack #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_from,
    input  logic [ADDR_W-1:0] push_to,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to,
    output logic [PTR_W-1:0]  tos
);
    logic [ADDR_W-1:0] from_q [DEPTH];
    logic [ADDR_W-1:0] to_q   [DEPTH];
    logic [PTR_W-1:0]  tos_nxt;

    // Next top-of-stack slot
    always_comb tos_nxt = tos + PTR_W'(1);

    // Pointer update and entry write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                from_q[i] <= '0;
                to_q[i]   <= '0;
            end
        end else if (push) begin
            tos             <= tos_nxt;
            from_q[tos_nxt] <= push_from;
            to_q[tos_nxt]   <= push_to;
        end
    end

    // Read port
    always_comb begin
        rd_from = from_q[rd_idx];
        rd_to   = to_q[rd_idx];
    end

    // R2
    tos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> tos == PTR_W'($past(tos) + 1));
    // R2
    tos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(tos));
    // R2
    top_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (from_q[tos] == $past(push_from)) && (to_q[tos] == $past(push_to)));
endmodule

// File: rtl/brt_msg_log.sv
// Module: trace message output and buffer logger.
// Owns the buffer base, limit and index registers. A write to the index
// register outranks a same-cycle log request and clears the interrupt.
// Assumes limit >= 1 and records of 2^REC_SH bytes.
module brt_msg_log #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int REC_SH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_fire,
    input  logic [1:0]          ev_kind,
    input  logic [ADDR_W-1:0]   ev_from,
    input  logic [ADDR_W-1:0]   ev_to,
    input  logic                msg_en,
    input  logic                log_en,
    input  logic                irq_mode,
    input  logic                wr_base,
    input  logic                wr_limit,
    input  logic                wr_index,
    input  logic [ADDR_W-1:0]   wdata_addr,
    input  logic [IDX_W-1:0]    wdata_idx,
    output logic                msg_valid,
    output logic [2*ADDR_W+1:0] msg_data,
    output logic                buf_we,
    output logic [ADDR_W-1:0]   buf_addr,
    output logic [2*ADDR_W-1:0] buf_wdata,
    output logic                buf_irq,
    output logic [ADDR_W-1:0]   base_q,
    output logic [IDX_W-1:0]    limit_q,
    output logic [IDX_W-1:0]    index_q
);
    logic             log_req;
    logic             at_full;
    logic [IDX_W-1:0] slot;
    logic [IDX_W-1:0] slot_inc;

    // Request and slot selection
    always_comb begin
        log_req  = ev_fire && msg_en && log_en;
        at_full  = (index_q >= limit_q);
        slot     = (at_full && !irq_mode) ? '0 : index_q;
        slot_inc = slot + IDX_W'(1);
    end

    // Trace message register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_data  <= '0;
        end else begin
            msg_valid <= ev_fire && msg_en;
            if (ev_fire && msg_en) msg_data <= {ev_kind, ev_from, ev_to};
        end
    end

    // Base and limit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else begin
            if (wr_base)  base_q  <= wdata_addr;
            if (wr_limit) limit_q <= wdata_idx;
        end
    end

    // Index, buffer write port and full interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q   <= '0;
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
            buf_irq   <= 1'b0;
        end else begin
            buf_we <= 1'b0;
            if (wr_index) begin
                index_q <= wdata_idx;
                buf_irq <= 1'b0;
            end else if (log_req) begin
                if (irq_mode && (at_full || buf_irq)) begin
                    buf_irq <= 1'b1;
                end else begin
                    buf_we    <= 1'b1;
                    buf_addr  <= base_q + (ADDR_W'(slot) << REC_SH);
                    buf_wdata <= {ev_from, ev_to};
                    if (slot_inc >= limit_q) begin
                        if (irq_mode) begin
                            index_q <= slot_inc;
                            buf_irq <= 1'b1;
                        end else begin
                            index_q <= '0;
                        end
                    end else begin
                        index_q <= slot_inc;
                    end
                end
            end
        end
    end

    // R6
    msg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(ev_fire && msg_en));
    // R7
    log_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(ev_fire && msg_en && log_en && !wr_index));
    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_irq) |-> $past(wr_index));
    // R8
    irq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(buf_irq) && $past(irq_mode) && !$past(wr_index)) |-> !buf_we);
    // R10
    idx_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index |=> !buf_we && (index_q == $past(wdata_idx)));
endmodule

// File: rtl/brt_unit.sv
// Module: branch trace recording unit, top level.
// Qualifies retirement events, decodes the register port and routes
// each qualifying event to the history stack and the message/log path.
// Assumes DEPTH is a power of two and the buffer limit is >= 1.
module brt_unit
    import brt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [1:0]          evt_kind,
    input  logic [ADDR_W-1:0]   evt_from,
    input  logic [ADDR_W-1:0]   evt_to,
    input  logic                reg_wr,
    input  logic [RA_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                msg_valid,
    output logic [2*ADDR_W+1:0] msg_data,
    output logic                buf_we,
    output logic [ADDR_W-1:0]   buf_addr,
    output logic [2*ADDR_W-1:0] buf_wdata,
    output logic                buf_irq
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int HIST_N = 2 * DEPTH;

    logic [REG_W-1:0]  ctrl_word;
    logic              ev_fire;
    logic [RA_W-1:0]   hoff;
    logic              in_hist;
    logic [PTR_W-1:0]  h_idx;
    logic [ADDR_W-1:0] h_from, h_to;
    logic [PTR_W-1:0]  tos;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  limit_q, index_q;

    // Event qualification and history window decode
    always_comb begin
        ev_fire = evt_valid && (evt_kind != EV_NOTTAKEN);
        hoff    = reg_addr - A_HIST;
        in_hist = (hoff < RA_W'(HIST_N));
        h_idx   = PTR_W'(hoff >> 1);
    end

    brt_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && (reg_addr == A_CTRL)),
        .wdata     (reg_wdata),
        .ctrl_word (ctrl_word)
    );

    brt_hist_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ev_fire && ctrl_word[CB_HIST]),
        .push_from (evt_from),
        .push_to   (evt_to),
        .rd_idx    (h_idx),
        .rd_from   (h_from),
        .rd_to     (h_to),
        .tos       (tos)
    );

    brt_msg_log #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_fire    (ev_fire),
        .ev_kind    (evt_kind),
        .ev_from    (evt_from),
        .ev_to      (evt_to),
        .msg_en     (ctrl_word[CB_MSG]),
        .log_en     (ctrl_word[CB_LOG]),
        .irq_mode   (ctrl_word[CB_FULL]),
        .wr_base    (reg_wr && (reg_addr == A_BASE)),
        .wr_limit   (reg_wr && (reg_addr == A_LIMIT)),
        .wr_index   (reg_wr && (reg_addr == A_INDEX)),
        .wdata_addr (ADDR_W'(reg_wdata)),
        .wdata_idx  (IDX_W'(reg_wdata)),
        .msg_valid  (msg_valid),
        .msg_data   (msg_data),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .buf_irq    (buf_irq),
        .base_q     (base_q),
        .limit_q    (limit_q),
        .index_q    (index_q)
    );

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (in_hist) begin
            reg_rdata = hoff[0] ? REG_W'(h_to) : REG_W'(h_from);
        end else begin
            case (reg_addr)
                A_CTRL:  reg_rdata = ctrl_word;
                A_BASE:  reg_rdata = REG_W'(base_q);
                A_LIMIT: reg_rdata = REG_W'(limit_q);
                A_INDEX: reg_rdata = REG_W'(index_q);
                A_TOS:   reg_rdata = REG_W'(tos);
                default: reg_rdata = '0;
            endcase
        end
    end

    // R4
    nottaken_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EV_NOTTAKEN) |=> !msg_valid && $stable(tos));
endmodule

// File: tb/brt_unit_tb.sv
`timescale 1ns/1ps
module brt_unit_tb;
    import brt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = '0;
    logic [31:0] evt_from = '0, evt_to = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid;
    logic [65:0] msg_data;
    logic        buf_we;
    logic [31:0] buf_addr;
    logic [63:0] buf_wdata;
    logic        buf_irq;

    int checks = 0;
    int errors = 0;
    int bwrites = 0;
    logic [63:0] bmem [16];

    always #2.5 clk = ~clk;

    brt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_from(evt_from), .evt_to(evt_to), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_data(msg_data), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_irq(buf_irq)
    );

    // Buffer memory model: commits a presented write at the next edge
    always @(posedge clk) begin
        if (rst_n && buf_we) begin
            bmem[buf_addr[6:3]] = buf_wdata;
            bwrites++;
        end
    end

    task automatic chk(input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; evt_valid = 1'b0; reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bwrites = 0;
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic send_ev(input logic [1:0] k, input logic [31:0] f, input logic [31:0] t);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = k; evt_from = f; evt_to = t;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd_reg(A_CTRL, v);  chk("R1 ctrl after reset", 66'(v), 66'(0));
        rd_reg(A_TOS, v);   chk("R2 tos after reset", 66'(v), 66'(0));
        chk("R6 msg_valid after reset", 66'(msg_valid), 66'(0));
        chk("R8 irq after reset", 66'(buf_irq), 66'(0));
    endtask

    task automatic t_ctrl_bits();
        logic [31:0] v;
        do_reset();
        wr_reg(A_CTRL, 32'hFFFF_FFFF);
        rd_reg(A_CTRL, v); chk("R1 ctrl keeps only bits 0,1,6,7,8", 66'(v), 66'(32'h1C3));
        wr_reg(A_CTRL, 32'h0000_0E3C);
        rd_reg(A_CTRL, v); chk("R1 ctrl reserved bits", 66'(v), 66'(32'h0));
    endtask

    task automatic t_step_flag();
        logic [31:0] v;
        do_reset();
        wr_reg(A_CTRL, 32'h2);
        rd_reg(A_CTRL, v); chk("R5 step flag reads back", 66'(v), 66'(2));
        send_ev(EV_TAKEN, 32'hA0, 32'hB0);
        chk("R5 step flag gives no message", 66'(msg_valid), 66'(0));
        rd_reg(A_TOS, v); chk("R5 step flag gives no push", 66'(v), 66'(0));
    endtask

    task automatic t_stack_push();
        logic [31:0] v;
        do_reset();
        send_ev(EV_TAKEN, 32'h11, 32'h22);
        rd_reg(A_TOS, v); chk("R2 disabled stack no push", 66'(v), 66'(0));
        wr_reg(A_CTRL, 32'h1);
        send_ev(EV_TAKEN, 32'h1000, 32'h2000);
        rd_reg(A_TOS, v); chk("R2 tos after taken", 66'(v), 66'(1));
        rd_reg(12'h042, v); chk("R2 entry1 source", 66'(v), 66'(32'h1000));
        rd_reg(12'h043, v); chk("R2 entry1 destination", 66'(v), 66'(32'h2000));
        send_ev(EV_INTR, 32'h3000, 32'h4000);
        send_ev(EV_EXCP, 32'h5000, 32'h6000);
        rd_reg(A_TOS, v); chk("R2 tos after interrupt and exception", 66'(v), 66'(3));
        rd_reg(12'h046, v); chk("R2 entry3 source", 66'(v), 66'(32'h5000));
        send_ev(EV_NOTTAKEN, 32'h7000, 32'h8000);
        rd_reg(A_TOS, v); chk("R4 not-taken no push", 66'(v), 66'(3));
    endtask

    task automatic t_stack_wrap();
        logic [31:0] v;
        do_reset();
        wr_reg(A_CTRL, 32'h1);
        for (int i = 1; i <= 9; i++) send_ev(EV_TAKEN, 32'(i), 32'(i + 100));
        rd_reg(A_TOS, v); chk("R3 tos wrap", 66'(v), 66'(1));
        rd_reg(12'h042, v); chk("R3 ninth overwrites oldest", 66'(v), 66'(9));
        rd_reg(12'h044, v); chk("R3 entry2 still second record", 66'(v), 66'(2));
        rd_reg(12'h041, v); chk("R3 entry0 holds eighth dest", 66'(v), 66'(108));
    endtask

    task automatic t_message();
        do_reset();
        wr_reg(A_CTRL, 32'h40);
        send_ev(EV_EXCP, 32'hCAFE, 32'hBEEF);
        chk("R6 msg_valid", 66'(msg_valid), 66'(1));
        chk("R6 msg_data", msg_data, {2'd3, 32'hCAFE, 32'hBEEF});
        @(negedge clk);
        chk("R6 msg one cycle", 66'(msg_valid), 66'(0));
        send_ev(EV_NOTTAKEN, 32'h1, 32'h2);
        chk("R4 not-taken no message", 66'(msg_valid), 66'(0));
        chk("R4 not-taken no buffer write", 66'(buf_we), 66'(0));
        wr_reg(A_CTRL, 32'h0);
        send_ev(EV_TAKEN, 32'h3, 32'h4);
        chk("R6 disabled no message", 66'(msg_valid), 66'(0));
    endtask

    task automatic t_log_needs_msg();
        logic [31:0] v;
        do_reset();
        wr_reg(A_LIMIT, 32'd4);
        wr_reg(A_CTRL, 32'h80);
        send_ev(EV_TAKEN, 32'h10, 32'h20);
        chk("R7 log without message no write", 66'(buf_we), 66'(0));
        rd_reg(A_INDEX, v); chk("R7 index unchanged", 66'(v), 66'(0));
    endtask

    task automatic t_log_circular();
        logic [31:0] v;
        do_reset();
        wr_reg(A_BASE, 32'h1000);
        wr_reg(A_LIMIT, 32'd3);
        wr_reg(A_INDEX, 32'd0);
        wr_reg(A_CTRL, 32'hC0);
        for (int i = 0; i < 4; i++) begin
            send_ev(EV_TAKEN, 32'h100 + 32'(i), 32'h200 + 32'(i));
            chk("R7 buf_we", 66'(buf_we), 66'(1));
            chk("R9 buf_addr", 66'(buf_addr), 66'(32'h1000 + 32'(8 * (i % 3))));
            chk("R7 buf_wdata", 66'(buf_wdata), 66'({32'h100 + 32'(i), 32'h200 + 32'(i)}));
        end
        rd_reg(A_INDEX, v); chk("R9 index after wrap", 66'(v), 66'(1));
        chk("R9 no irq in circular mode", 66'(buf_irq), 66'(0));
        @(negedge clk);
        chk("R9 base slot overwritten", 66'(bmem[0]), 66'({32'h103, 32'h203}));
        chk("R7 write count", 66'(bwrites), 66'(4));
    endtask

    task automatic t_log_irq();
        logic [31:0] v;
        do_reset();
        wr_reg(A_BASE, 32'h2000);
        wr_reg(A_LIMIT, 32'd2);
        wr_reg(A_CTRL, 32'h1C0);
        send_ev(EV_TAKEN, 32'hA1, 32'hB1);
        chk("R7 first slot", 66'(buf_addr), 66'(32'h2000));
        chk("R8 irq low before full", 66'(buf_irq), 66'(0));
        send_ev(EV_INTR, 32'hA2, 32'hB2);
        chk("R7 second slot", 66'(buf_addr), 66'(32'h2008));
        chk("R8 irq at full", 66'(buf_irq), 66'(1));
        send_ev(EV_TAKEN, 32'hA3, 32'hB3);
        chk("R8 no write when full", 66'(buf_we), 66'(0));
        chk("R8 irq held", 66'(buf_irq), 66'(1));
        rd_reg(A_INDEX, v); chk("R8 index at limit", 66'(v), 66'(2));
        wr_reg(A_INDEX, 32'd0);
        chk("R8 index write clears irq", 66'(buf_irq), 66'(0));
        send_ev(EV_TAKEN, 32'hA4, 32'hB4);
        chk("R8 logging resumes at base", 66'(buf_addr), 66'(32'h2000));
        chk("R8 resumed write strobe", 66'(buf_we), 66'(1));
    endtask

    task automatic t_index_priority();
        logic [31:0] v;
        do_reset();
        wr_reg(A_BASE, 32'h3000);
        wr_reg(A_LIMIT, 32'd8);
        wr_reg(A_CTRL, 32'hC0);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = EV_TAKEN; evt_from = 32'h55; evt_to = 32'h66;
        reg_wr = 1'b1; reg_addr = A_INDEX; reg_wdata = 32'd5;
        @(negedge clk);
        evt_valid = 1'b0; reg_wr = 1'b0;
        chk("R10 index write wins, no buffer write", 66'(buf_we), 66'(0));
        chk("R10 message still sent", 66'(msg_valid), 66'(1));
        rd_reg(A_INDEX, v); chk("R10 index takes written value", 66'(v), 66'(5));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_ctrl_bits();
        t_step_flag();
        t_stack_push();
        t_stack_wrap();
        t_message();
        t_log_needs_msg();
        t_log_circular();
        t_log_irq();
        t_index_priority();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..: run did not complete actual=hung expected=done");
        finish_run();
    end
endmodule